// File: doc/BRIEF.md
# Enhanced Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with three framed modes. In the standard mode a frame carries eight data bits. In the two extended modes it carries a ninth, programmable bit. A receiver oversamples the line at sixteen times the bit rate. An optional holding buffer lets software queue the next transmit byte while the current frame is still shifting out. Reception reports framing errors, breaks and overruns in a status byte. A transmit-ready flag and a receive-ready flag drive two interrupt outputs.

Software sees one write port. Address 0 is control: bits 1:0 select the mode (0 off, 1 standard 8-bit, 2 nine-bit at a fixed clock ratio, 3 nine-bit from the divisor generator), bit 2 selects the fast fixed ratio, bit 3 enables the holding buffer, bit 4 enables the receiver and bit 5 enables the divisor generator. Addresses 1 and 2 hold the low and high divisor bytes. Address 3 takes transmit data and address 4 bit 0 takes the ninth transmit bit. Address 5 clears flags: each 1 in bits 4:0 clears the status flag at the same position. The status byte holds ri (bit 0), ti (bit 1), framing error (bit 2), break (bit 3) and overrun (bit 4), and its upper bits read 0. The received byte and the received extra bit sit on their own outputs.

Top module: `uart_enh`

## Requirements
- R1: After reset txd is 1, status is 0, rx_data and rx_bit8 are 0 and both interrupt outputs are 0.
- R2: In mode 1 a transmitted frame is a 0 start bit, eight data bits with the least significant bit first, and a 1 stop bit. Each bit lasts 16*(divisor+16) clocks when the generator is enabled.
- R3: In modes 2 and 3 a transmitted frame is a start bit, eight data bits with the least significant bit first, the ninth bit, then a 1 stop bit.
- R4: In mode 2 a bit lasts 16 clocks with the fast bit set and 32 clocks with it clear. txd changes only in the cycle after an oversample tick.
- R5: Divisor writes take effect only while the generator enable is 0. A divisor write made while it is 1 is ignored and the bit time stays the same.
- R6: With the holding buffer on, a byte written while a frame shifts is sent next, after exactly one stop bit. ti sets when the buffered byte moves into the shifter, not at the end of the frame.
- R7: With the holding buffer on, the ninth bit is taken at the data write. Changing it afterwards does not alter that frame.
- R8: With the holding buffer off, ti sets at the end of the stop bit. A data write made while a frame is in progress is ignored and no extra frame is sent.
- R9: In mode 1 a received frame places its byte on rx_data and its stop bit on rx_bit8, and sets ri (irq_rx follows ri).
- R10: In modes 2 and 3 the received ninth bit is placed on rx_bit8.
- R11: A stop bit sampled as 0 sets the framing-error flag together with ri. The receiver then waits for the line to return high before it looks for a new start bit.
- R12: A line held low for frame-length*16 consecutive oversample ticks sets the break flag. The flag stays set until cleared through address 5.
- R13: A frame that completes while ri is still set sets the overrun flag, and the newer byte replaces rx_data.
- R14: A start bit is accepted only if the majority of samples 7, 8 and 9 is low. A shorter low pulse produces no reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| rx_data | output | 8 | Last received byte |
| rx_bit8 | output | 1 | Received stop bit (mode 1) or ninth bit (modes 2, 3) |
| status | output | 8 | {3'b0, overrun, break, framing error, ti, ri} |
| irq_tx | output | 1 | Transmit interrupt, follows ti |
| irq_rx | output | 1 | Receive interrupt, follows ri |

## Verification
The bench measures the spacing between start edges of back-to-back frames in every rate configuration. If the shifter reloaded one tick late, or inserted an extra idle bit between frames, the measured gap would be longer than the expected multiple of the bit time. It also changes the ninth bit right after queuing a byte: a design that read that bit at load time instead of at the write would send the wrong ninth bit. Several reception cases are driven. A zero stop bit must flag a framing error without a break. A long low period must flag a break. Two unread frames must flag an overrun. A short low glitch must not start a reception; a receiver that trusted the first low sample would report a spurious byte.

// File: rtl/uart_enh_pkg.sv
package uart_enh_pkg;
    localparam int DATA_W  = 8;
    localparam int OS_RATE = 16;
    localparam int OS_W    = $clog2(OS_RATE);
    localparam int VOTE_AT = OS_RATE / 2 + 1;
    localparam int FRM_MAX = DATA_W + 3;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_DIVLO = 3'd1,
        A_DIVHI = 3'd2,
        A_TXDAT = 3'd3,
        A_TX9   = 3'd4,
        A_CLR   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        M_OFF      = 2'd0,
        M_STD8     = 2'd1,
        M_NINE_FIX = 2'd2,
        M_NINE_GEN = 2'd3
    } mode_e;

    typedef struct packed {
        logic  gen_en;
        logic  rx_en;
        logic  dbuf;
        logic  fast;
        mode_e mode;
    } ctrl_t;

    typedef struct packed {
        logic ovr;
        logic brk;
        logic fe;
        logic ti;
        logic ri;
    } flags_t;

    typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_WAITHI} rx_state_e;

    function automatic logic [3:0] frame_bits(input mode_e m);
        return (m == M_STD8) ? 4'(DATA_W + 2) : 4'(DATA_W + 3);
    endfunction

    function automatic logic [FRM_MAX-1:0] build_frame(input mode_e m,
                                                       input logic [DATA_W-1:0] d,
                                                       input logic b9);
        logic extra;
        extra = (m == M_STD8) ? 1'b1 : b9;
        return {1'b1, extra, d, 1'b0};
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/uart_enh_baud.sv
module uart_enh_baud
    import uart_enh_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  mode_e            mode,
    input  logic             fast,
    input  logic             gen_en,
    input  logic [DIV_W-1:0] div,
    output logic             os_tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             run;

    always_comb begin
        run = (mode == M_NINE_FIX) ||
              (((mode == M_STD8) || (mode == M_NINE_GEN)) && gen_en);
        if (mode == M_NINE_FIX)
            lim = fast ? CNT_W'(0) : CNT_W'(1);
        else
            lim = {1'b0, div} + CNT_W'(OS_RATE - 1);
        os_tick = run && (cnt >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt >= lim)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/uart_enh_tx.sv
module uart_enh_tx
    import uart_enh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  mode_e             mode,
    input  logic              dbuf,
    input  logic              wr_dat,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx9,
    output logic              txd,
    output logic              ti_set
);
    logic               buf_full;
    logic [DATA_W:0]    buf_q;
    logic               active;
    logic [FRM_MAX-1:0] sh;
    logic [3:0]         left;
    logic [OS_W-1:0]    sub;
    logic               accept;
    logic               last_shift;
    logic               load;

    always_comb begin
        accept     = wr_dat && !buf_full && (dbuf || !active);
        last_shift = active && os_tick && (sub == OS_W'(OS_RATE - 1)) && (left == 4'd1);
        load       = os_tick && buf_full && (mode != M_OFF) && (!active || last_shift);
        ti_set     = dbuf ? load : last_shift;
        txd        = active ? sh[0] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full <= 1'b0;
            buf_q    <= '0;
        end else if (accept) begin
            buf_full <= 1'b1;
            buf_q    <= {tx9, wdata};
        end else if (load) begin
            buf_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sh     <= '1;
            left   <= '0;
            sub    <= '0;
        end else if (load) begin
            active <= 1'b1;
            sh     <= build_frame(mode, buf_q[DATA_W-1:0], buf_q[DATA_W]);
            left   <= frame_bits(mode);
            sub    <= '0;
        end else if (active && os_tick) begin
            sub <= sub + OS_W'(1);
            if (sub == OS_W'(OS_RATE - 1)) begin
                sh   <= {1'b1, sh[FRM_MAX-1:1]};
                left <= left - 4'd1;
                if (left == 4'd1)
                    active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/uart_enh_rx.sv
module uart_enh_rx
    import uart_enh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rx_en,
    input  mode_e             mode,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              bit8,
    output logic              stop_bad,
    output logic              brk_hit
);
    logic              rxm, rxs;
    rx_state_e         st;
    logic [OS_W-1:0]   cnt;
    logic [3:0]        idx;
    logic [1:0]        hist;
    logic [DATA_W-1:0] sh;
    logic              b9;
    logic [7:0]        low_cnt;
    logic [3:0]        nb;
    logic [7:0]        brk_lim;
    logic              vote;
    logic              vote_now;

    always_comb begin
        nb       = frame_bits(mode);
        brk_lim  = {nb, 4'b0000};
        vote     = maj3(hist[1], hist[0], rxs);
        vote_now = (st == RX_RUN) && os_tick && (cnt == OS_W'(VOTE_AT));
        done     = vote_now && (idx == nb - 4'd1);
        stop_bad = !vote;
        bit8     = (mode == M_STD8) ? vote : b9;
        data     = sh;
        brk_hit  = os_tick && rx_en && !rxs && (low_cnt == brk_lim - 8'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rxm <= 1'b1;
            rxs <= 1'b1;
        end else begin
            rxm <= rxd;
            rxs <= rxm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            st   <= RX_IDLE;
            cnt  <= '0;
            idx  <= '0;
            hist <= '0;
            sh   <= '0;
            b9   <= 1'b0;
        end else begin
            case (st)
                RX_IDLE: begin
                    if (os_tick && !rxs) begin
                        st  <= RX_RUN;
                        cnt <= OS_W'(1);
                        idx <= '0;
                    end
                end
                RX_RUN: begin
                    if (os_tick) begin
                        hist <= {hist[0], rxs};
                        cnt  <= cnt + OS_W'(1);
                        if (cnt == OS_W'(OS_RATE - 1))
                            idx <= idx + 4'd1;
                    end
                    if (vote_now) begin
                        if (idx == 4'd0) begin
                            if (vote)
                                st <= RX_IDLE;
                        end else if (idx <= 4'(DATA_W)) begin
                            sh <= {vote, sh[DATA_W-1:1]};
                        end else if (!done) begin
                            b9 <= vote;
                        end
                        if (done)
                            st <= vote ? RX_IDLE : RX_WAITHI;
                    end
                end
                default: begin
                    if (rxs)
                        st <= RX_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en)
            low_cnt <= '0;
        else if (os_tick) begin
            if (rxs)
                low_cnt <= '0;
            else if (low_cnt != 8'hFF)
                low_cnt <= low_cnt + 8'd1;
        end
    end
endmodule

// File: rtl/uart_enh.sv
module uart_enh
    import uart_enh_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rxd,
    output logic        txd,
    output logic [7:0]  rx_data,
    output logic        rx_bit8,
    output logic [7:0]  status,
    output logic        irq_tx,
    output logic        irq_rx
);
    ctrl_t             ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic              tx9_q;
    flags_t            flags_q;
    flags_t            clr_mask;
    flags_t            set_mask;
    logic              os_tick;
    logic              ti_set;
    logic              rx_done;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_b8;
    logic              stop_bad;
    logic              brk_hit;
    logic              wr_dat;

    always_comb begin
        wr_dat   = wr_en && (wr_addr == A_TXDAT);
        clr_mask = (wr_en && (wr_addr == A_CLR)) ? flags_t'(wr_data[4:0]) : flags_t'('0);
        set_mask.ri  = rx_done;
        set_mask.ti  = ti_set;
        set_mask.fe  = rx_done && stop_bad;
        set_mask.brk = brk_hit;
        set_mask.ovr = rx_done && flags_q.ri;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            tx9_q  <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL:  ctrl_q <= ctrl_t'(wr_data[5:0]);
                A_DIVLO: if (!ctrl_q.gen_en) div_q[7:0] <= wr_data;
                A_DIVHI: if (!ctrl_q.gen_en) div_q[DIV_W-1:8] <= wr_data[DIV_W-9:0];
                A_TX9:   tx9_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            rx_data <= '0;
            rx_bit8 <= 1'b0;
        end else begin
            flags_q <= flags_t'((flags_q & ~clr_mask) | set_mask);
            if (rx_done) begin
                rx_data <= rx_byte;
                rx_bit8 <= rx_b8;
            end
        end
    end

    uart_enh_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .fast(ctrl_q.fast),
        .gen_en(ctrl_q.gen_en), .div(div_q), .os_tick(os_tick)
    );

    uart_enh_tx u_tx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .mode(ctrl_q.mode),
        .dbuf(ctrl_q.dbuf), .wr_dat(wr_dat), .wdata(wr_data), .tx9(tx9_q),
        .txd(txd), .ti_set(ti_set)
    );

    uart_enh_rx u_rx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_en(ctrl_q.rx_en),
        .mode(ctrl_q.mode), .rxd(rxd), .done(rx_done), .data(rx_byte),
        .bit8(rx_b8), .stop_bad(stop_bad), .brk_hit(brk_hit)
    );

    assign status = {3'b000, flags_q};
    assign irq_tx = flags_q.ti;
    assign irq_rx = flags_q.ri;
endmodule

// File: rtl/uart_enh_chk.sv
module uart_enh_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             txd,
    input logic             os_tick,
    input logic [7:0]       status,
    input logic             brk_clr,
    input logic             gen_en,
    input logic [DIV_W-1:0] div_q
);
    // R4: the line only moves on the oversample grid
    a_r4_txd_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(os_tick));

    // R11: a framing error is always reported with a completed frame
    a_r11_fe_with_ri: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> status[0]);

    // R13: overrun needs an unread frame in the cycle before
    a_r13_ovr_after_ri: assert property (@(posedge clk) disable iff (rst)
        $rose(status[4]) |-> $past(status[0]));

    // R12: break stays until explicitly cleared
    a_r12_brk_sticky: assert property (@(posedge clk) disable iff (rst)
        (status[3] && !brk_clr) |=> status[3]);

    // R5: divisor is frozen while the generator runs
    a_r5_div_locked: assert property (@(posedge clk) disable iff (rst)
        gen_en |=> $stable(div_q));
endmodule

bind uart_enh uart_enh_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .txd(txd), .os_tick(os_tick), .status(status),
    .brk_clr(clr_mask.brk), .gen_en(ctrl_q.gen_en), .div_q(div_q)
);

// File: tb/sim_uart_enh.sv
`timescale 1ns/1ps
module sim_uart_enh;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rxd = 1'b1;
    logic       txd;
    logic [7:0] rx_data;
    logic       rx_bit8;
    logic [7:0] status;
    logic       irq_tx;
    logic       irq_rx;

    always #10 clk = ~clk;

    uart_enh u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rxd(rxd), .txd(txd), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .status(status), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    int n_chk = 0;
    int n_fail = 0;
    int bitclk = 16;
    int nbits = 11;
    string mon_req = "R3";
    logic [8:0] exp_q[$];
    realtime starts[$];

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tx_push(input logic [7:0] d, input logic b9);
        exp_q.push_back({b9, d});
        reg_wr(3'd4, {7'b0, b9});
        reg_wr(3'd3, d);
    endtask

    task automatic tx_push_wait(input logic [7:0] d, input logic b9);
        tx_push(d, b9);
        wait (irq_tx == 1'b1);
        reg_wr(3'd5, 8'h02);
    endtask

    task automatic drain;
        wait (exp_q.size() == 0);
        repeat (2 * bitclk) @(negedge clk);
    endtask

    task automatic rx_send(input logic [10:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            rxd = bits[i];
            repeat (bitclk) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic spacing(input string req);
        int gap;
        gap = (starts.size() >= 2) ? int'(starts[1] - starts[0]) : -1;
        check(gap == nbits * bitclk * 20, req, gap, nbits * bitclk * 20, "start-to-start gap ns");
    endtask

    // monitor: decodes frames on txd and compares against the scoreboard queue
    initial begin
        forever begin
            logic [9:0] got;
            logic [8:0] e;
            @(negedge txd);
            if (rst) continue;
            starts.push_back($realtime);
            #(bitclk * 10);
            check(txd == 1'b0, mon_req, txd, 0, "start bit");
            got = '0;
            for (int i = 0; i < nbits - 1; i++) begin
                #(bitclk * 20);
                got[i] = txd;
            end
            check(got[nbits-2] == 1'b1, mon_req, got[nbits-2], 1, "stop bit");
            if (exp_q.size() == 0) begin
                check(1'b0, mon_req, got, 0, "unexpected frame");
            end else begin
                e = exp_q.pop_front();
                check(got[7:0] == e[7:0], mon_req, got[7:0], e[7:0], "data byte");
                if (nbits == 11)
                    check(got[8] == e[8], mon_req, got[8], e[8], "ninth bit");
            end
        end
    end

    initial begin
        #3_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1", txd, 1, "txd idle");
        check(status == 8'h00, "R1", status, 0, "status");
        check(rx_data == 8'h00 && rx_bit8 == 1'b0, "R1", rx_data, 0, "rx_data");
        check(irq_tx == 1'b0 && irq_rx == 1'b0, "R1", {irq_tx, irq_rx}, 0, "irqs");

        // R3 R6 R7: mode 2 fast, holding buffer on
        bitclk = 16; nbits = 11; mon_req = "R3";
        reg_wr(3'd0, 8'h1E);
        starts.delete();
        tx_push(8'hA5, 1'b1);
        repeat (4) @(negedge clk);
        check(irq_tx == 1'b1, "R6", irq_tx, 1, "ti when buffer frees");
        reg_wr(3'd5, 8'h02);
        mon_req = "R7";
        tx_push(8'h3C, 1'b0);
        reg_wr(3'd4, 8'h01);
        repeat (2) @(negedge clk);
        check(irq_tx == 1'b0, "R6", irq_tx, 0, "ti while buffer full");
        wait (starts.size() == 2);
        repeat (3) @(negedge clk);
        check(irq_tx == 1'b1, "R6", irq_tx, 1, "ti after reload");
        drain();
        spacing("R6");

        // R4: mode 2 slow rate
        mon_req = "R4"; bitclk = 32;
        reg_wr(3'd0, 8'h1A);
        reg_wr(3'd5, 8'h02);
        starts.delete();
        tx_push_wait(8'h69, 1'b0);
        tx_push_wait(8'h96, 1'b1);
        drain();
        spacing("R4");

        // R2: mode 1 from generator, divisor 0
        mon_req = "R2"; bitclk = 256; nbits = 10;
        reg_wr(3'd0, 8'h19);
        reg_wr(3'd1, 8'h00);
        reg_wr(3'd2, 8'h00);
        reg_wr(3'd0, 8'h39);
        starts.delete();
        tx_push_wait(8'h5A, 1'b0);
        tx_push_wait(8'hC3, 1'b0);
        drain();
        spacing("R2");

        // R5: divisor write while generator on is ignored
        mon_req = "R5"; bitclk = 320; nbits = 11;
        reg_wr(3'd0, 8'h1B);
        reg_wr(3'd1, 8'h04);
        reg_wr(3'd0, 8'h3B);
        reg_wr(3'd1, 8'h00);
        starts.delete();
        tx_push_wait(8'h81, 1'b1);
        tx_push_wait(8'h7E, 1'b0);
        drain();
        spacing("R5");

        // R8: single buffer
        mon_req = "R8"; bitclk = 16; nbits = 11;
        reg_wr(3'd0, 8'h16);
        reg_wr(3'd5, 8'h1F);
        tx_push(8'h11, 1'b0);
        repeat (80) @(negedge clk);
        check(irq_tx == 1'b0, "R8", irq_tx, 0, "ti mid-frame");
        reg_wr(3'd3, 8'h22);
        wait (exp_q.size() == 0);
        repeat (bitclk + 4) @(negedge clk);
        check(irq_tx == 1'b1, "R8", irq_tx, 1, "ti at frame end");
        repeat (3 * 11 * 16) @(negedge clk);
        check(txd == 1'b1 && exp_q.size() == 0, "R8", txd, 1, "no extra frame");

        // R10: nine-bit reception
        reg_wr(3'd5, 8'h1F);
        rx_send({1'b1, 1'b1, 8'h96, 1'b0}, 11);
        check(rx_data == 8'h96, "R10", rx_data, 8'h96, "rx byte");
        check(rx_bit8 == 1'b1, "R10", rx_bit8, 1, "rx ninth bit");
        check(status == 8'h01 && irq_rx == 1'b1, "R10", status, 1, "ri only");

        // R9: mode 1 reception
        bitclk = 256;
        reg_wr(3'd0, 8'h19);
        reg_wr(3'd1, 8'h00);
        reg_wr(3'd0, 8'h39);
        reg_wr(3'd5, 8'h1F);
        rx_send({1'b0, 1'b1, 8'h4E, 1'b0}, 10);
        check(rx_data == 8'h4E, "R9", rx_data, 8'h4E, "rx byte");
        check(rx_bit8 == 1'b1, "R9", rx_bit8, 1, "stop into rx_bit8");
        check(irq_rx == 1'b1, "R9", irq_rx, 1, "irq_rx");

        // R11: framing error
        bitclk = 16;
        reg_wr(3'd0, 8'h16);
        reg_wr(3'd5, 8'h1F);
        rx_send({1'b0, 1'b0, 8'hFF, 1'b0}, 11);
        repeat (8) @(negedge clk);
        check(status == 8'h05, "R11", status, 8'h05, "fe and ri, no break");
        check(rx_data == 8'hFF, "R11", rx_data, 8'hFF, "rx byte");

        // R13: overrun
        reg_wr(3'd5, 8'h1F);
        rx_send({1'b1, 1'b0, 8'h12, 1'b0}, 11);
        rx_send({1'b1, 1'b0, 8'h34, 1'b0}, 11);
        check(status[4] == 1'b1, "R13", status, 8'h11, "overrun flag");
        check(rx_data == 8'h34, "R13", rx_data, 8'h34, "newer byte kept");

        // R12: break
        reg_wr(3'd5, 8'h1F);
        rxd = 1'b0;
        repeat (12 * 16) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check(status[3] == 1'b1, "R12", status, 8'h0D, "break flag");
        repeat (100) @(negedge clk);
        check(status[3] == 1'b1, "R12", status[3], 1, "break sticky");
        reg_wr(3'd5, 8'h08);
        check(status[3] == 1'b0, "R12", status[3], 0, "break cleared");

        // R14: short glitch rejected
        reg_wr(3'd5, 8'h1F);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * 11 * 16) @(negedge clk);
        check(status == 8'h00, "R14", status, 0, "no reception from glitch");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule